// File: doc/BRIEF.md
# PRG Outer Bank Translator

This block builds the final 8 KiB program-ROM bank number for a CPU access in the 0x8000–0xFFFF window of a cartridge memory controller. An inner bank controller supplies an 8-bit page number. The translator merges that page with a set of outer bank registers: a board variant number, a 3-bit banking mode, a 7-bit base, a 4-bit high base and an extended-mode flag. The variant decides which merge rule applies. Within the variants that honour it, the mode sets how many bits come from the base and how many from the inner page. This covers 512, 256 and 128 KiB windows, fixed 16 KiB and 32 KiB layouts and a switchable-plus-fixed layout.

The result is the bank number plus the 13-bit offset inside the bank. The output passes through an optional pipeline register, controlled by parameter `REG_OUT`, which is 1 by default. With that register present, results appear one clock after the inputs are presented. Accesses to 0x6000–0x7FFF are not handled here.

Top module: `prg_outer_xlate`

## Requirements
- R1: In variants 1 and 2 with `extEnable`=1, bank = ((base & 0x7F) << 1) | (inner & 1). This rule overrides the banking mode.
- R2: `extEnable` has no effect on the bank in variants 0, 3, 4, 5, 6 and 7.
- R3: In variants 0, 2 and 4 (variant 2 only with `extEnable`=0), the mode value sets the window. Mode 0 gives ((base & 3) << 6) | (inner & 0x3F). Mode 1 gives ((base & 7) << 5) | (inner & 0x1F). Mode 2 gives ((base & 0xF) << 4) | (inner & 0xF).
- R4: Under the same variants, mode 3 (16 KiB, mirrored) gives ((base & 0x3F) << 1) | (inner & 1).
- R5: Under the same variants, mode 4 (32 KiB) gives (((base & 0x3F) << 1) & 0xFC) | (inner & 3).
- R6: Under the same variants, mode 5 gives ((base & 0x3F) << 1) | (inner & 7).
- R7: Under the same variants, modes 6 and 7 pass the inner page through unchanged.
- R8: Variants 1 (with `extEnable`=0) and 3 give ((high & 0xF) << 8) | ((base & 0x7F) << 1) | inner. The high base counts only in variant 3; variant 1 treats it as zero.
- R9: Variant 5 gives ((base & 0x3F) << 6) | (inner & 0x3F).
- R10: Variants 6 and 7 pass the inner page through unchanged, whatever the mode.
- R11: `offsetOut` equals the CPU address bits [12:0].
- R12: With `REG_OUT`=1, both outputs are zero during reset. Each result appears at the first rising clock edge after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| variant | input | 3 | Board variant number, 0..7 |
| bankMode | input | 3 | Banking mode field |
| base | input | 7 | Outer PRG base |
| highBase | input | 4 | Outer PRG high base (variant 3) |
| extEnable | input | 1 | Extended single-bit-inner mode flag |
| cpuAddrLo | input | 13 | CPU address bits [12:0] |
| innerPage | input | 8 | Inner 8 KiB page from the inner controller |
| bankOut | output | 12 | Final 8 KiB bank number |
| offsetOut | output | 13 | Byte offset within the bank |

## Verification
The bench sweeps every variant, mode and extended-flag setting against inner pages and bases whose bits are set on both sides of each merge boundary. A design that drew its window split one bit off would corrupt the bit at that boundary. One that dropped the 0xFC mask in the 32 KiB mode would let base bit 0 reach bank bit 1. Extended mode is applied in variants 3 and 5 as well as 1 and 2, so a design that honoured it everywhere would replace those banks. Variant 1 is driven with a nonzero high base: using that base outside variant 3 would set bank bits [11:8].

// File: rtl/prgx_pkg.sv
package prgx_pkg;
  localparam int INNER_W = 8;
  localparam int BASE_W  = 7;
  localparam int HIGH_W  = 4;
  localparam int OFFS_W  = 13;
  localparam int BANK_W  = HIGH_W + INNER_W;

  typedef struct packed {
    logic       ext;       // extended single-inner-bit rule
    logic       narrow;    // mode-selected window rule
    logic       wide;      // full inner page plus shifted base
    logic       useHigh;   // high base contributes (wide rule only)
    logic       hiOuter;   // base above six inner bits
    logic       passThru;  // inner page unchanged
    logic [2:0] mode;
  } strobe_t;
endpackage

// File: rtl/prgx_ctrl.sv
module prgx_ctrl
  import prgx_pkg::*;
(
  input  logic [2:0] variant,
  input  logic [2:0] bankMode,
  input  logic       extEnable,
  output strobe_t    strb
);
  logic extVariant;
  logic narrowVariant;

  always_comb begin
    extVariant    = (variant == 3'd1) || (variant == 3'd2);
    narrowVariant = (variant == 3'd0) || (variant == 3'd2) || (variant == 3'd4);
    strb.ext      = extEnable && extVariant;
    strb.narrow   = !strb.ext && narrowVariant;
    strb.wide     = !strb.ext && ((variant == 3'd1) || (variant == 3'd3));
    strb.useHigh  = (variant == 3'd3);
    strb.hiOuter  = (variant == 3'd5);
    strb.passThru = (variant == 3'd6) || (variant == 3'd7);
    strb.mode     = bankMode;
  end

  // R2: exactly one merge rule is chosen for every input combination
  always_comb begin
    a_r2_one_rule: assert ($countones({strb.ext, strb.narrow, strb.wide,
                                       strb.hiOuter, strb.passThru}) == 1)
      else $error("merge rule select not one-hot");
  end
endmodule

// File: rtl/prgx_datapath.sv
module prgx_datapath
  import prgx_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [BASE_W-1:0]   base,
  input  logic [HIGH_W-1:0]   highBase,
  input  logic [OFFS_W-1:0]   cpuAddrLo,
  input  logic [INNER_W-1:0]  innerPage,
  output logic [BANK_W-1:0]   bankOut,
  output logic [OFFS_W-1:0]   offsetOut
);
  logic [BANK_W-1:0] b, i, h;
  logic [BANK_W-1:0] narrowBank;
  logic [BANK_W-1:0] nextBank;

  always_comb begin
    b = BANK_W'(base);
    i = BANK_W'(innerPage);
    h = strb.useHigh ? BANK_W'(highBase) : '0;
    unique case (strb.mode)
      3'd0:    narrowBank = ((b & BANK_W'('h03)) << 6) | (i & BANK_W'('h3F));
      3'd1:    narrowBank = ((b & BANK_W'('h07)) << 5) | (i & BANK_W'('h1F));
      3'd2:    narrowBank = ((b & BANK_W'('h0F)) << 4) | (i & BANK_W'('h0F));
      3'd3:    narrowBank = ((b & BANK_W'('h3F)) << 1) | (i & BANK_W'('h01));
      3'd4:    narrowBank = (((b & BANK_W'('h3F)) << 1) & BANK_W'('hFC)) | (i & BANK_W'('h03));
      3'd5:    narrowBank = ((b & BANK_W'('h3F)) << 1) | (i & BANK_W'('h07));
      default: narrowBank = i;
    endcase
    if (strb.ext)
      nextBank = ((b & BANK_W'('h7F)) << 1) | (i & BANK_W'('h01));
    else if (strb.narrow)
      nextBank = narrowBank;
    else if (strb.wide)
      nextBank = ((h & BANK_W'('h0F)) << INNER_W) | ((b & BANK_W'('h7F)) << 1) | i;
    else if (strb.hiOuter)
      nextBank = ((b & BANK_W'('h3F)) << 6) | (i & BANK_W'('h3F));
    else
      nextBank = i;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic primed;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bankOut   <= '0;
          offsetOut <= '0;
          primed    <= 1'b0;
        end else begin
          bankOut   <= nextBank;
          offsetOut <= cpuAddrLo;
          primed    <= 1'b1;
        end
      end

      a_r11_offset: assert property (@(posedge clk) disable iff (!rstN)
        primed |-> offsetOut == $past(cpuAddrLo));
      a_r1_ext_low_bit: assert property (@(posedge clk) disable iff (!rstN)
        primed && $past(strb.ext) |->
          bankOut[0] == $past(innerPage[0]) && bankOut[BANK_W-1:INNER_W] == '0);
      a_r10_pass: assert property (@(posedge clk) disable iff (!rstN)
        primed && $past(strb.passThru) |-> bankOut == BANK_W'($past(innerPage)));
      a_r9_low_six: assert property (@(posedge clk) disable iff (!rstN)
        primed && $past(strb.hiOuter) |-> bankOut[5:0] == $past(innerPage[5:0]));
      a_r3_narrow_top: assert property (@(posedge clk) disable iff (!rstN)
        primed && $past(strb.narrow) |-> bankOut[BANK_W-1:INNER_W] == '0);
    end else begin : g_comb
      assign bankOut   = nextBank;
      assign offsetOut = cpuAddrLo;
      logic unusedClk;
      assign unusedClk = clk ^ rstN;
    end
  endgenerate
endmodule

// File: rtl/prg_outer_xlate.sv
module prg_outer_xlate
  import prgx_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          variant,
  input  logic [2:0]          bankMode,
  input  logic [BASE_W-1:0]   base,
  input  logic [HIGH_W-1:0]   highBase,
  input  logic                extEnable,
  input  logic [OFFS_W-1:0]   cpuAddrLo,
  input  logic [INNER_W-1:0]  innerPage,
  output logic [BANK_W-1:0]   bankOut,
  output logic [OFFS_W-1:0]   offsetOut
);
  strobe_t strb;

  prgx_ctrl u_ctrl (
    .variant   (variant),
    .bankMode  (bankMode),
    .extEnable (extEnable),
    .strb      (strb)
  );

  prgx_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .base      (base),
    .highBase  (highBase),
    .cpuAddrLo (cpuAddrLo),
    .innerPage (innerPage),
    .bankOut   (bankOut),
    .offsetOut (offsetOut)
  );
endmodule

// File: tb/sim_prg_outer_xlate.sv
module sim_prg_outer_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  variant = '0;
  logic [2:0]  bankMode = '0;
  logic [6:0]  base = '0;
  logic [3:0]  highBase = '0;
  logic        extEnable = 1'b0;
  logic [12:0] cpuAddrLo = '0;
  logic [7:0]  innerPage = '0;
  logic [11:0] bankOut;
  logic [12:0] offsetOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prg_outer_xlate u0 (
    .clk(clk), .rstN(rstN), .variant(variant), .bankMode(bankMode),
    .base(base), .highBase(highBase), .extEnable(extEnable),
    .cpuAddrLo(cpuAddrLo), .innerPage(innerPage),
    .bankOut(bankOut), .offsetOut(offsetOut)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (v=%0d m=%0d x=%0d b=%0h h=%0h i=%0h)",
               req, actual, expected, variant, bankMode, extEnable, base, highBase, innerPage);
    end
  endtask

  function automatic int expBank(int v, int m, int x, int b, int h, int i, output string req);
    if ((v == 1 || v == 2) && x == 1) begin
      req = "R1"; return ((b & 'h7F) << 1) | (i & 1);
    end
    if (v == 0 || v == 2 || v == 4) begin
      case (m)
        0: begin req = "R3"; return ((b & 3) << 6) | (i & 'h3F); end
        1: begin req = "R3"; return ((b & 7) << 5) | (i & 'h1F); end
        2: begin req = "R3"; return ((b & 'hF) << 4) | (i & 'hF); end
        3: begin req = "R4"; return ((b & 'h3F) << 1) | (i & 1); end
        4: begin req = "R5"; return (((b & 'h3F) << 1) & 'hFC) | (i & 3); end
        5: begin req = "R6"; return ((b & 'h3F) << 1) | (i & 7); end
        default: begin req = "R7"; return i; end
      endcase
    end
    if (v == 1 || v == 3) begin
      req = "R8";
      return (((v == 3) ? (h & 'hF) : 0) << 8) | ((b & 'h7F) << 1) | i;
    end
    if (v == 5) begin req = "R9"; return ((b & 'h3F) << 6) | (i & 'h3F); end
    req = "R10"; return i;
  endfunction

  initial begin
    int baseSet[5]  = '{'h00, 'h01, 'h2A, 'h55, 'h7F};
    int innerSet[5] = '{'h00, 'h01, 'h3C, 'hA5, 'hFF};
    int highSet[2]  = '{'h0, 'h9};
    string req;
    int e;
    int addr;
    // R12: reset state with nonzero inputs
    variant = 3'd3; base = 7'h7F; highBase = 4'hF; innerPage = 8'hFF; cpuAddrLo = 13'h1ABC;
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset bank", int'(bankOut), 0);
    check("R12 reset offset", int'(offsetOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    addr = 0;
    for (int v = 0; v < 8; v++)
      for (int m = 0; m < 8; m++)
        for (int x = 0; x < 2; x++)
          for (int bi = 0; bi < 5; bi++)
            for (int ii = 0; ii < 5; ii++)
              for (int hi = 0; hi < 2; hi++) begin
                @(negedge clk);
                variant = 3'(v); bankMode = 3'(m); extEnable = x[0];
                base = 7'(baseSet[bi]); innerPage = 8'(innerSet[ii]);
                highBase = 4'(highSet[hi]);
                addr = (addr * 37 + 'h0B5D) & 'h1FFF;
                cpuAddrLo = 13'(addr);
                e = expBank(v, m, x, baseSet[bi], highSet[hi], innerSet[ii], req);
                // R12: value visible only after the next rising edge
                @(posedge clk);
                #1;
                if (x == 1 && !(v == 1 || v == 2)) req = {req, "/R2"};
                check(req, int'(bankOut), e);
                check("R11 offset", int'(offsetOut), addr);
              end
    // R12: one-cycle latency, output holds old value until the edge
    @(negedge clk);
    variant = 3'd6; innerPage = 8'h11;
    @(posedge clk); #1;
    @(negedge clk);
    innerPage = 8'h22;
    #1;
    check("R12 hold before edge", int'(bankOut), 'h11);
    @(posedge clk); #1;
    check("R12 update after edge", int'(bankOut), 'h22);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule